// File: doc/BRIEF.md
# Memory Protection Rule Table

This block sits in front of a memory controller and decides, for every transaction, whether it may proceed. It keeps a small table of protection rules. Each rule names a range of 1 MiB pages, a window of transaction IDs, the security classes it covers, the source ports it applies to, and the verdict it gives, accept or reject. A transaction that matches no rule gets the verdict of a per-port default bit.

Software never reaches the table directly. It fills three staging registers (page range, ID window, attributes) and then writes a command register. The command register holds a rule number and two strobe bits. One strobe bit copies the staging registers into the rule. The other copies the rule back into the staging registers so that software can read it. The check port takes the page number, ID, security class and port of a transaction. One clock cycle later it returns a registered verdict.

Top module: `mem_guard`

## Requirements
- R1: After reset every rule is invalid, the default register is zero (all ports accept), and all five registers read back zero. A check made in this state is accepted.
- R2: Writing register 0 with bit 5 set copies the staged page range, ID window and attributes into the rule numbered by bits [4:0]. Writing register 0 with bit 6 set (and bit 5 clear) copies that rule into the three staging registers. When both bits are set, only the copy into the rule takes place.
- R3: Register 0 reads back the last rule number written in bits [4:0], and bits 5 and above read as zero. A copy in either direction that names a rule number of NUM_RULES or more has no effect.
- R4: Register 1 holds the first page in bits [11:0] and the last page in bits [23:12]. A transaction on page p is inside the range when first <= p <= last, with both ends included.
- R5: Register 2 holds the lowest ID in bits [11:0] and the highest ID in bits [23:12]. Both ends of the window are included.
- R6: In register 3, bits [1:0] select security classes. Bit 0 admits class-0 transactions and bit 1 admits class-1 transactions.
- R7: In register 3, bits [12:3] are a port mask. Bit 3+k admits port k.
- R8: A rule with its valid bit (register 3 bit 2) clear never matches. Committing all-zero staging registers clears a rule.
- R9: In register 3, bit 13 is the rule's verdict (0 accept, 1 reject). When several rules match, the lowest-numbered one decides.
- R10: Register 4 holds one default bit per port (0 accept, 1 reject). It decides every transaction that matches no rule.
- R11: rsp_valid is high exactly in the cycle after a cycle with chk_valid high, and carries that check's verdict in rsp_reject. A port number of NUM_PORTS or more is always rejected.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| cfg_wr | input | 1 | Register write strobe |
| cfg_sel | input | 3 | Register select: 0 command, 1 page range, 2 ID window, 3 attributes, 4 default |
| cfg_wdata | input | 24 | Write data |
| cfg_rdata | output | 24 | Read data of the selected register (combinational) |
| chk_valid | input | 1 | A transaction is presented for checking |
| chk_page | input | 12 | Address bits [31:20] of the transaction (its 1 MiB page) |
| chk_id | input | 12 | Transaction ID |
| chk_sec | input | 1 | Security class of the transaction |
| chk_port | input | 4 | Source port number |
| rsp_valid | output | 1 | Verdict valid, one cycle after chk_valid |
| rsp_reject | output | 1 | 1 rejects the transaction, 0 accepts it |

## Verification
The cases that are hardest to reach from the ports are the ones the register window itself hides. These are a command word with both strobes set, and a command that names a rule number beyond the table. Neither shows up in the verdict unless the stimulus is built for it. The bench stages a rule whose effect can be seen, issues the unusual command, and then reads the staging registers back and checks transactions that only that rule would decide. Several of the verdict checks fall exactly on a first page, a last page or a window-edge ID. Overlapping rules with opposite verdicts are then committed and cleared in turn, which exposes the lowest-number priority.

// File: rtl/mpt_pkg.sv
package mpt_pkg;
    localparam int FLD_W    = 12;
    localparam int DATA_W   = 2 * FLD_W;
    localparam int MASK_W   = 10;
    localparam int SEC_W    = 2;
    localparam int ATTR_W   = SEC_W + 1 + MASK_W + 1;
    localparam int CMD_IDX_W = 5;
    localparam int CMD_COMMIT = 5;
    localparam int CMD_LOAD   = 6;
    localparam int PORT_W   = 4;

    typedef enum logic [2:0] {
        REG_CMD   = 3'd0,
        REG_RANGE = 3'd1,
        REG_IDWIN = 3'd2,
        REG_ATTR  = 3'd3,
        REG_DFLT  = 3'd4
    } reg_sel_e;

    typedef struct packed {
        logic [FLD_W-1:0]  lo_pg;
        logic [FLD_W-1:0]  hi_pg;
        logic [FLD_W-1:0]  lo_id;
        logic [FLD_W-1:0]  hi_id;
        logic [SEC_W-1:0]  sec;
        logic              valid;
        logic [MASK_W-1:0] ports;
        logic              verdict;
    } rule_t;
endpackage

// File: rtl/mpt_regs.sv
module mpt_regs
    import mpt_pkg::*;
#(
    parameter int NUM_RULES = 20,
    parameter int NUM_PORTS = 10
) (
    input  logic                 clk,
    input  logic                 rst_n,
    input  logic                 cfg_wr,
    input  logic [2:0]           cfg_sel,
    input  logic [DATA_W-1:0]    cfg_wdata,
    output logic [DATA_W-1:0]    cfg_rdata,
    output rule_t                rules_o [NUM_RULES],
    output logic [NUM_PORTS-1:0] dflt_o
);
    typedef struct packed {
        logic [CMD_IDX_W-1:0] sel;
        logic [DATA_W-1:0]    range;
        logic [DATA_W-1:0]    idwin;
        logic [ATTR_W-1:0]    attr;
        logic [NUM_PORTS-1:0] dflt;
    } win_t;

    win_t  win_d, win_q;
    rule_t tbl_d [NUM_RULES];
    rule_t tbl_q [NUM_RULES];

    always_comb begin
        win_d = win_q;
        for (int i = 0; i < NUM_RULES; i++) tbl_d[i] = tbl_q[i];
        if (cfg_wr) begin
            case (cfg_sel)
                REG_CMD: begin
                    win_d.sel = cfg_wdata[CMD_IDX_W-1:0];
                    for (int i = 0; i < NUM_RULES; i++) begin
                        if (cfg_wdata[CMD_IDX_W-1:0] == i[CMD_IDX_W-1:0]) begin
                            if (cfg_wdata[CMD_COMMIT]) begin
                                tbl_d[i].lo_pg   = win_q.range[FLD_W-1:0];
                                tbl_d[i].hi_pg   = win_q.range[DATA_W-1:FLD_W];
                                tbl_d[i].lo_id   = win_q.idwin[FLD_W-1:0];
                                tbl_d[i].hi_id   = win_q.idwin[DATA_W-1:FLD_W];
                                tbl_d[i].sec     = win_q.attr[SEC_W-1:0];
                                tbl_d[i].valid   = win_q.attr[SEC_W];
                                tbl_d[i].ports   = win_q.attr[SEC_W+1 +: MASK_W];
                                tbl_d[i].verdict = win_q.attr[ATTR_W-1];
                            end else if (cfg_wdata[CMD_LOAD]) begin
                                win_d.range = {tbl_q[i].hi_pg, tbl_q[i].lo_pg};
                                win_d.idwin = {tbl_q[i].hi_id, tbl_q[i].lo_id};
                                win_d.attr  = {tbl_q[i].verdict, tbl_q[i].ports,
                                               tbl_q[i].valid, tbl_q[i].sec};
                            end
                        end
                    end
                end
                REG_RANGE: win_d.range = cfg_wdata;
                REG_IDWIN: win_d.idwin = cfg_wdata;
                REG_ATTR:  win_d.attr  = cfg_wdata[ATTR_W-1:0];
                REG_DFLT:  win_d.dflt  = cfg_wdata[NUM_PORTS-1:0];
                default: ;
            endcase
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            win_q <= '0;
            for (int i = 0; i < NUM_RULES; i++) tbl_q[i] <= '0;
        end else begin
            win_q <= win_d;
            for (int i = 0; i < NUM_RULES; i++) tbl_q[i] <= tbl_d[i];
        end
    end

    always_comb begin
        case (cfg_sel)
            REG_CMD:   cfg_rdata = DATA_W'(win_q.sel);
            REG_RANGE: cfg_rdata = win_q.range;
            REG_IDWIN: cfg_rdata = win_q.idwin;
            REG_ATTR:  cfg_rdata = DATA_W'(win_q.attr);
            REG_DFLT:  cfg_rdata = DATA_W'(win_q.dflt);
            default:   cfg_rdata = '0;
        endcase
    end

    assign rules_o = tbl_q;
    assign dflt_o  = win_q.dflt;
endmodule

// File: rtl/mpt_match.sv
module mpt_match
    import mpt_pkg::*;
#(
    parameter int NUM_RULES = 20,
    localparam int IDX_W    = CMD_IDX_W
) (
    input  rule_t              rules_i [NUM_RULES],
    input  logic [FLD_W-1:0]   page,
    input  logic [FLD_W-1:0]   id,
    input  logic               sec,
    input  logic [PORT_W-1:0]  port,
    output logic [NUM_RULES-1:0] hit_vec,
    output logic               any_hit,
    output logic [IDX_W-1:0]   win_idx,
    output logic               win_verdict
);
    logic [(1<<PORT_W)-1:0] port_sel;
    assign port_sel = (1 << PORT_W)'(1) << port;

    for (genvar g = 0; g < NUM_RULES; g++) begin : g_rule
        logic pg_ok, id_ok, sec_ok, port_ok;
        assign pg_ok   = (page >= rules_i[g].lo_pg) && (page <= rules_i[g].hi_pg);
        assign id_ok   = (id >= rules_i[g].lo_id) && (id <= rules_i[g].hi_id);
        assign sec_ok  = sec ? rules_i[g].sec[1] : rules_i[g].sec[0];
        assign port_ok = |(rules_i[g].ports & port_sel[MASK_W-1:0]);
        assign hit_vec[g] = rules_i[g].valid && pg_ok && id_ok && sec_ok && port_ok;
    end

    always_comb begin
        win_idx     = '0;
        win_verdict = 1'b0;
        for (int i = NUM_RULES - 1; i >= 0; i--) begin
            if (hit_vec[i]) begin
                win_idx     = i[IDX_W-1:0];
                win_verdict = rules_i[i].verdict;
            end
        end
    end

    assign any_hit = |hit_vec;
endmodule

// File: rtl/mem_guard.sv
module mem_guard
    import mpt_pkg::*;
#(
    parameter int NUM_RULES = 20,
    parameter int NUM_PORTS = 10
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              cfg_wr,
    input  logic [2:0]        cfg_sel,
    input  logic [DATA_W-1:0] cfg_wdata,
    output logic [DATA_W-1:0] cfg_rdata,
    input  logic              chk_valid,
    input  logic [FLD_W-1:0]  chk_page,
    input  logic [FLD_W-1:0]  chk_id,
    input  logic              chk_sec,
    input  logic [PORT_W-1:0] chk_port,
    output logic              rsp_valid,
    output logic              rsp_reject
);
    typedef struct packed {
        logic valid;
        logic reject;
    } rsp_t;

    rule_t                  rules [NUM_RULES];
    logic [NUM_PORTS-1:0]   dflt;
    logic [NUM_RULES-1:0]   hit_vec;
    logic                   any_hit;
    logic [CMD_IDX_W-1:0]   win_idx;
    logic                   win_verdict;
    logic [(1<<PORT_W)-1:0] port_sel;
    logic                   port_in_range;
    logic                   dflt_bit;
    rsp_t                   rsp_d, rsp_q;

    mpt_regs #(.NUM_RULES(NUM_RULES), .NUM_PORTS(NUM_PORTS)) u_regs (
        .clk(clk), .rst_n(rst_n),
        .cfg_wr(cfg_wr), .cfg_sel(cfg_sel), .cfg_wdata(cfg_wdata),
        .cfg_rdata(cfg_rdata), .rules_o(rules), .dflt_o(dflt)
    );

    mpt_match #(.NUM_RULES(NUM_RULES)) u_match (
        .rules_i(rules), .page(chk_page), .id(chk_id), .sec(chk_sec),
        .port(chk_port), .hit_vec(hit_vec), .any_hit(any_hit),
        .win_idx(win_idx), .win_verdict(win_verdict)
    );

    assign port_sel      = (1 << PORT_W)'(1) << chk_port;
    assign port_in_range = 32'(chk_port) < NUM_PORTS;
    assign dflt_bit      = |(dflt & port_sel[NUM_PORTS-1:0]);

    always_comb begin
        rsp_d.valid  = chk_valid;
        rsp_d.reject = chk_valid &&
                       (!port_in_range || (any_hit ? win_verdict : dflt_bit));
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) rsp_q <= '0;
        else        rsp_q <= rsp_d;
    end

    assign rsp_valid  = rsp_q.valid;
    assign rsp_reject = rsp_q.reject;
endmodule

// File: rtl/mem_guard_chk.sv
module mem_guard_chk
    import mpt_pkg::*;
#(
    parameter int NUM_RULES = 20,
    parameter int NUM_PORTS = 10
) (
    input logic                 clk,
    input logic                 rst_n,
    input logic                 chk_valid,
    input logic [PORT_W-1:0]    chk_port,
    input logic [2:0]           cfg_sel,
    input logic [DATA_W-1:0]    cfg_rdata,
    input rule_t                rules [NUM_RULES],
    input logic [NUM_PORTS-1:0] dflt,
    input logic [NUM_RULES-1:0] hit_vec,
    input logic                 any_hit,
    input logic [CMD_IDX_W-1:0] win_idx,
    input logic                 rsp_valid,
    input logic                 rsp_reject
);
    logic win_valid, lower_hit, win_hit, port_dflt;

    always_comb begin
        win_valid = 1'b0;
        win_hit   = 1'b0;
        lower_hit = 1'b0;
        for (int i = 0; i < NUM_RULES; i++) begin
            if (win_idx == i[CMD_IDX_W-1:0]) begin
                win_valid = rules[i].valid;
                win_hit   = hit_vec[i];
            end
            if (32'(win_idx) > i && hit_vec[i]) lower_hit = 1'b1;
        end
        port_dflt = 1'b0;
        for (int k = 0; k < NUM_PORTS; k++)
            if (chk_port == k[PORT_W-1:0]) port_dflt = dflt[k];
    end

    a_r11_rsp_follows_chk: assert property (@(posedge clk) disable iff (!rst_n)
        chk_valid |=> rsp_valid);
    a_r11_no_spurious_rsp: assert property (@(posedge clk) disable iff (!rst_n)
        !chk_valid |=> !rsp_valid);
    a_r11_bad_port_rejects: assert property (@(posedge clk) disable iff (!rst_n)
        (chk_valid && 32'(chk_port) >= NUM_PORTS) |=> rsp_reject);
    a_r8_winner_is_valid: assert property (@(posedge clk) disable iff (!rst_n)
        any_hit |-> win_valid);
    a_r9_lowest_wins: assert property (@(posedge clk) disable iff (!rst_n)
        any_hit |-> (win_hit && !lower_hit));
    a_r10_default_decides: assert property (@(posedge clk) disable iff (!rst_n)
        (chk_valid && !any_hit && 32'(chk_port) < NUM_PORTS) |=> (rsp_reject == $past(port_dflt)));
    a_r3_cmd_strobes_clear: assert property (@(posedge clk) disable iff (!rst_n)
        (cfg_sel == 3'd0) |-> (cfg_rdata[DATA_W-1:CMD_IDX_W] == '0));
endmodule

bind mem_guard mem_guard_chk #(.NUM_RULES(NUM_RULES), .NUM_PORTS(NUM_PORTS)) u_chk (
    .clk(clk), .rst_n(rst_n), .chk_valid(chk_valid), .chk_port(chk_port),
    .cfg_sel(cfg_sel), .cfg_rdata(cfg_rdata), .rules(rules), .dflt(dflt),
    .hit_vec(hit_vec), .any_hit(any_hit), .win_idx(win_idx),
    .rsp_valid(rsp_valid), .rsp_reject(rsp_reject)
);

// File: tb/mem_guard_test.sv
module mem_guard_test;
    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        cfg_wr = 1'b0;
    logic [2:0]  cfg_sel = 3'd0;
    logic [23:0] cfg_wdata = '0;
    logic [23:0] cfg_rdata;
    logic        chk_valid = 1'b0;
    logic [11:0] chk_page = '0;
    logic [11:0] chk_id = '0;
    logic        chk_sec = 1'b0;
    logic [3:0]  chk_port = '0;
    logic        rsp_valid, rsp_reject;

    int n_tests = 0;
    int n_fail  = 0;
    bit exp_q[$];
    string tag_q[$];

    always #2 clk = ~clk;

    mem_guard uut (
        .clk(clk), .rst_n(rst_n), .cfg_wr(cfg_wr), .cfg_sel(cfg_sel),
        .cfg_wdata(cfg_wdata), .cfg_rdata(cfg_rdata), .chk_valid(chk_valid),
        .chk_page(chk_page), .chk_id(chk_id), .chk_sec(chk_sec),
        .chk_port(chk_port), .rsp_valid(rsp_valid), .rsp_reject(rsp_reject)
    );

    // monitor: pops the scoreboard as verdicts appear
    always @(negedge clk) begin
        if (rst_n && rsp_valid) begin
            n_tests++;
            if (exp_q.size() == 0) begin
                n_fail++;
                $display("FAIL R11 unexpected rsp_valid: actual 1 expected 0");
            end else begin
                bit e;
                string t;
                e = exp_q.pop_front();
                t = tag_q.pop_front();
                if (rsp_reject !== e) begin
                    n_fail++;
                    $display("FAIL %s: rsp_reject actual %0b expected %0b", t, rsp_reject, e);
                end
            end
        end
    end

    task automatic wr(input logic [2:0] sel, input logic [23:0] d);
        @(negedge clk);
        chk_valid = 1'b0;
        cfg_wr = 1'b1; cfg_sel = sel; cfg_wdata = d;
        @(negedge clk);
        cfg_wr = 1'b0;
    endtask

    task automatic rd(input logic [2:0] sel, input logic [23:0] exp, input string tag);
        @(negedge clk);
        chk_valid = 1'b0;
        cfg_sel = sel;
        #1;
        n_tests++;
        if (cfg_rdata !== exp) begin
            n_fail++;
            $display("FAIL %s: reg %0d actual %h expected %h", tag, sel, cfg_rdata, exp);
        end
    endtask

    task automatic stage(input logic [11:0] lo_pg, input logic [11:0] hi_pg,
                         input logic [11:0] lo_id, input logic [11:0] hi_id,
                         input logic [1:0] sec, input logic vld,
                         input logic [9:0] ports, input logic verdict);
        wr(3'd1, {hi_pg, lo_pg});
        wr(3'd2, {hi_id, lo_id});
        wr(3'd3, {10'd0, verdict, ports, vld, sec});
    endtask

    task automatic txn(input logic [11:0] pg, input logic [11:0] id, input logic sec,
                       input logic [3:0] port, input bit exp, input string tag);
        @(negedge clk);
        chk_valid = 1'b1; chk_page = pg; chk_id = id; chk_sec = sec; chk_port = port;
        exp_q.push_back(exp);
        tag_q.push_back(tag);
    endtask

    task automatic idle(input int n);
        for (int i = 0; i < n; i++) begin
            @(negedge clk);
            chk_valid = 1'b0;
        end
    endtask

    initial begin
        #400000;
        n_fail++;
        $display("FAIL watchdog: actual timeout expected completion");
        $display("  [TB] %0d tests run, %0d failed", n_tests, n_fail);
        $finish;
    end

    initial begin
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        // R1 reset state
        for (int r = 0; r < 5; r++) rd(3'(r), 24'h0, "R1 reset readback");
        txn(12'd5, 12'd1, 1'b1, 4'd3, 1'b0, "R1 empty table accepts");
        idle(2);

        // R10 default decides unmatched
        wr(3'd4, 24'h3FE);
        txn(12'd5, 12'd1, 1'b0, 4'd0, 1'b0, "R10 default bit0=0 accepts");
        txn(12'd5, 12'd1, 1'b0, 4'd1, 1'b1, "R10 default bit1=1 rejects");
        idle(2);
        wr(3'd4, 24'h3FF);

        // rule 3: pages 16..31, ids 5..9, class 0 only, ports 1,2, accept
        stage(12'd16, 12'd31, 12'd5, 12'd9, 2'b01, 1'b1, 10'h006, 1'b0);
        wr(3'd0, 24'h23);
        txn(12'd16, 12'd5, 1'b0, 4'd1, 1'b0, "R4 first page inside");
        txn(12'd31, 12'd5, 1'b0, 4'd1, 1'b0, "R4 last page inside");
        txn(12'd15, 12'd5, 1'b0, 4'd1, 1'b1, "R4 below first page");
        txn(12'd32, 12'd5, 1'b0, 4'd1, 1'b1, "R4 above last page");
        txn(12'd20, 12'd4, 1'b0, 4'd1, 1'b1, "R5 id below window");
        txn(12'd20, 12'd9, 1'b0, 4'd1, 1'b0, "R5 id at top of window");
        txn(12'd20, 12'd10, 1'b0, 4'd1, 1'b1, "R5 id above window");
        txn(12'd20, 12'd6, 1'b1, 4'd1, 1'b1, "R6 class 1 not admitted");
        txn(12'd20, 12'd6, 1'b0, 4'd0, 1'b1, "R7 port 0 not in mask");
        txn(12'd20, 12'd6, 1'b0, 4'd2, 1'b0, "R7 port 2 in mask");
        txn(12'd20, 12'd6, 1'b0, 4'd12, 1'b1, "R11 port beyond range");
        idle(3);

        // R2 load back rule 3, R3 strobes read zero
        stage(12'd0, 12'd0, 12'd0, 12'd0, 2'b00, 1'b0, 10'h0, 1'b0);
        wr(3'd0, 24'h43);
        rd(3'd1, {12'd31, 12'd16}, "R2 load page range");
        rd(3'd2, {12'd9, 12'd5}, "R2 load id window");
        rd(3'd3, 24'h000035, "R2 load attributes");
        rd(3'd0, 24'h000003, "R3 command readback");

        // R9 rule 1 overlapping with reject verdict wins
        stage(12'd16, 12'd31, 12'd0, 12'hFFF, 2'b11, 1'b1, 10'h3FF, 1'b1);
        wr(3'd0, 24'h21);
        txn(12'd16, 12'd5, 1'b0, 4'd1, 1'b1, "R9 lower rule 1 rejects over rule 3");
        idle(2);
        // R8 clear rule 1 with all-zero staging
        stage(12'd0, 12'd0, 12'd0, 12'd0, 2'b00, 1'b0, 10'h0, 1'b0);
        wr(3'd0, 24'h21);
        txn(12'd16, 12'd5, 1'b0, 4'd1, 1'b0, "R8 cleared rule 1 no longer matches");
        // R8 invalid rule with wide fields never matches
        stage(12'd0, 12'hFFF, 12'd0, 12'hFFF, 2'b11, 1'b0, 10'h3FF, 1'b0);
        wr(3'd0, 24'h27);
        txn(12'd100, 12'd1, 1'b0, 4'd0, 1'b1, "R8 invalid rule 7 ignored");
        idle(2);

        // R2 both strobes: only the commit happens
        stage(12'd200, 12'd210, 12'd0, 12'hFFF, 2'b11, 1'b1, 10'h3FF, 1'b0);
        wr(3'd0, 24'h62);
        rd(3'd1, {12'd210, 12'd200}, "R2 both strobes keep staging");
        txn(12'd205, 12'd7, 1'b1, 4'd0, 1'b0, "R2 both strobes commit rule 2");
        idle(2);

        // R3 out-of-range rule number
        stage(12'd300, 12'd310, 12'd0, 12'hFFF, 2'b11, 1'b1, 10'h3FF, 1'b0);
        wr(3'd0, 24'h34);
        rd(3'd0, 24'h000014, "R3 command keeps number 20");
        txn(12'd305, 12'd7, 1'b0, 4'd0, 1'b1, "R3 commit to rule 20 ignored");
        idle(2);
        wr(3'd0, 24'h59);
        rd(3'd1, {12'd310, 12'd300}, "R3 load from rule 25 ignored");

        idle(4);
        n_tests++;
        if (exp_q.size() != 0) begin
            n_fail++;
            $display("FAIL R11 missing responses: actual %0d pending expected 0", exp_q.size());
        end
        $display("  [TB] %0d tests run, %0d failed", n_tests, n_fail);
        $finish;
    end
endmodule